// File: doc/BRIEF.md
# Router Power-Gating Handshake Controller

This controller sits beside one mesh router and decides when the router datapath is switched off and when it is brought back. It gates the router only after the datapath reports empty. It warns all four neighbors through a per-neighbor gated flag one cycle before the sleep control rises. It then keeps that flag raised until the router is usable again, so the neighbors hold back traffic bound for it.

There are two wake policies, chosen by a mode input. In the neighbor policy, a wake request from any neighbor starts the wakeup. In the decoupled policy, neighbor wake requests are ignored. The controller instead counts virtual-channel requests from the local network interface over a fixed window, and it wakes the router when a window count goes above a programmable threshold. A wakeup always takes a fixed number of cycles. Each time the router leaves the off state, a status flag records whether the off period lasted long enough to pay back the gating cost.

The controller also produces the router's own wake requests toward neighbors that are gated while the router has traffic for them.

Top module: `router_gate_ctrl`

## Requirements
- R1: After reset the controller is powered on: sleepOut=0, every pgOut bit 0, routerReady=1, betMet=0.
- R2: From the on state, a cycle with dpEmpty=1 and no wake trigger moves the controller to a one-cycle drain check. If dpEmpty is still 1 there and no trigger is present, it enters off (sleepOut=1) on the next cycle. If dpEmpty has dropped to 0, it returns to on without sleeping.
- R3: All pgOut bits go to 1 in the drain-check cycle, one cycle before sleepOut rises. They stay 1 through off and waking, and they return to 0 in the same cycle that routerReady returns to 1. routerReady is 0 whenever pgOut is 1.
- R4: With modeSel=0, any nbrWake bit set while off is the wake trigger. sleepOut falls in the next cycle, while pgOut stays 1.
- R5: routerReady returns to 1, and pgOut to 0, exactly WAKE_LAT cycles after the first cycle with sleepOut low following the trigger (default 12).
- R6: With modeSel=1, the wake trigger is a flag updated once every WIN_LEN cycles. Windows start at the first clock edge after reset. The flag is set when the number of cycles in the window with vcReq=1 is strictly greater than rateThresh; a count equal to the threshold does not set it. In this mode nbrWake has no effect.
- R7: A wake trigger present in the drain-check cycle aborts gating. The controller returns to on in the next cycle, and sleepOut is never raised.
- R8: When the controller leaves off, betMet becomes 1 if the off state lasted at least BET_CYC cycles (default 10), and 0 otherwise. It holds its value at all other times.
- R9: wuOut[i] equals sendReq[i] AND nbrPg[i] in the same cycle, for each neighbor i.

Bit i of nbrWake, nbrPg, sendReq, pgOut and wuOut all refer to the same neighbor i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0: neighbor wake policy, 1: request-rate wake policy |
| dpEmpty | input | 1 | Router datapath holds no flits |
| vcReq | input | 1 | A local VC request this cycle |
| rateThresh | input | RATE_W | Request count that a window must exceed to wake |
| nbrWake | input | NUM_NBR | Wake requests from neighbors |
| nbrPg | input | NUM_NBR | Gated flags from neighbors |
| sendReq | input | NUM_NBR | Local traffic waiting for each neighbor |
| sleepOut | output | 1 | Sleep control to the power switch |
| pgOut | output | NUM_NBR | Gated flag to each neighbor |
| wuOut | output | NUM_NBR | Wake request to each neighbor |
| routerReady | output | 1 | Router is powered and usable |
| betMet | output | 1 | Last off period reached the breakeven time |

## Verification
A state register stuck or mis-sequenced shows up within a cycle or two of the stimulus: sleepOut rises without pgOut leading it, or pgOut and routerReady disagree. A wrong wake counter moves the rising edge of routerReady by whole cycles, so it is caught by checking that exact cycle. The window counter and rate threshold show only at the next window boundary, as a wakeup a window early, a window late or never. A wrong off-period count shows only at the next exit from off, through betMet, so off periods of exactly BET_CYC and BET_CYC-1 cycles are used.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_DRAIN = 2'd1,
    ST_OFF   = 2'd2,
    ST_WAKE  = 2'd3
  } gateState_t;

  typedef struct packed {
    logic inOff;
    logic inWake;
    logic offStart;
    logic offExit;
  } ctlStrobe_t;

endpackage

// File: rtl/pgc_datapath.sv
module pgc_datapath
  import pgc_pkg::*;
#(
  parameter int WAKE_LAT = 12,
  parameter int BET_CYC  = 10,
  parameter int WIN_LEN  = 32,
  parameter int RATE_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcReq,
  input  logic [RATE_W-1:0] rateThresh,
  input  ctlStrobe_t        strobe,
  output logic              wakeDone,
  output logic              rateHigh,
  output logic              betMet
);

  localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int WAKE_W = $clog2(WAKE_LAT + 1);
  localparam int OFF_W  = $clog2(BET_CYC + 1);

  logic [WIN_W-1:0]  winCnt;
  logic [RATE_W-1:0] reqCnt;
  logic [WAKE_W-1:0] wakeCnt;
  logic [OFF_W-1:0]  offCnt;
  logic              winEnd;

  assign winEnd   = (int'(winCnt) == WIN_LEN - 1);
  assign wakeDone = strobe.inWake && (int'(wakeCnt) == WAKE_LAT - 1);

  // request-rate window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      reqCnt   <= '0;
      rateHigh <= 1'b0;
    end else if (winEnd) begin
      winCnt   <= '0;
      reqCnt   <= '0;
      rateHigh <= (int'(reqCnt) + int'(vcReq)) > int'(rateThresh);
    end else begin
      winCnt <= winCnt + 1'b1;
      reqCnt <= reqCnt + RATE_W'(vcReq);
    end
  end

  // wakeup latency counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (strobe.offExit) begin
      wakeCnt <= '0;
    end else if (strobe.inWake && !wakeDone) begin
      wakeCnt <= wakeCnt + 1'b1;
    end
  end

  // gated-off duration and breakeven status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
      betMet <= 1'b0;
    end else begin
      if (strobe.offStart) begin
        offCnt <= '0;
      end else if (strobe.inOff && int'(offCnt) < BET_CYC) begin
        offCnt <= offCnt + 1'b1;
      end
      if (strobe.offExit) begin
        betMet <= (int'(offCnt) + 1) >= BET_CYC;
      end
    end
  end

  assert_wake_cnt_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(wakeCnt) <= WAKE_LAT - 1);

  assert_req_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(reqCnt) <= int'(winCnt));

  assert_bet_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.offExit |=> $stable(betMet));

endmodule

// File: rtl/pgc_control.sv
module pgc_control
  import pgc_pkg::*;
#(
  parameter int NUM_NBR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSel,
  input  logic               dpEmpty,
  input  logic [NUM_NBR-1:0] nbrWake,
  input  logic               rateHigh,
  input  logic               wakeDone,
  output ctlStrobe_t         strobe,
  output logic               sleepAct,
  output logic               pgAct,
  output logic               readyAct
);

  gateState_t state, stateNxt;
  logic       wakeTrig;

  assign wakeTrig = modeSel ? rateHigh : (|nbrWake);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_ON:    if (dpEmpty && !wakeTrig) stateNxt = ST_DRAIN;
      ST_DRAIN: stateNxt = (wakeTrig || !dpEmpty) ? ST_ON : ST_OFF;
      ST_OFF:   if (wakeTrig) stateNxt = ST_WAKE;
      ST_WAKE:  if (wakeDone) stateNxt = ST_ON;
      default:  stateNxt = ST_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ON;
    else       state <= stateNxt;
  end

  assign sleepAct = (state == ST_OFF);
  assign pgAct    = (state != ST_ON);
  assign readyAct = (state == ST_ON);

  always_comb begin
    strobe.inOff    = (state == ST_OFF);
    strobe.inWake   = (state == ST_WAKE);
    strobe.offStart = (state == ST_DRAIN) && (stateNxt == ST_OFF);
    strobe.offExit  = (state == ST_OFF) && (stateNxt == ST_WAKE);
  end

  assert_empty_before_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepAct) |-> $past(dpEmpty));

  assert_pg_leads_sleep_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepAct) |-> $past(pgAct));

  assert_trig_drops_sleep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && wakeTrig) |=> (!sleepAct && pgAct));

  assert_abort_no_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && wakeTrig) |=> (readyAct && !sleepAct));

endmodule

// File: rtl/router_gate_ctrl.sv
module router_gate_ctrl
  import pgc_pkg::*;
#(
  parameter  int NUM_NBR  = 4,
  parameter  int WAKE_LAT = 12,
  parameter  int BET_CYC  = 10,
  parameter  int WIN_LEN  = 32,
  localparam int RATE_W   = $clog2(WIN_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSel,
  input  logic               dpEmpty,
  input  logic               vcReq,
  input  logic [RATE_W-1:0]  rateThresh,
  input  logic [NUM_NBR-1:0] nbrWake,
  input  logic [NUM_NBR-1:0] nbrPg,
  input  logic [NUM_NBR-1:0] sendReq,
  output logic               sleepOut,
  output logic [NUM_NBR-1:0] pgOut,
  output logic [NUM_NBR-1:0] wuOut,
  output logic               routerReady,
  output logic               betMet
);

  ctlStrobe_t strobe;
  logic       wakeDone;
  logic       rateHigh;
  logic       pgAct;

  pgc_control #(
    .NUM_NBR(NUM_NBR)
  ) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .dpEmpty (dpEmpty),
    .nbrWake (nbrWake),
    .rateHigh(rateHigh),
    .wakeDone(wakeDone),
    .strobe  (strobe),
    .sleepAct(sleepOut),
    .pgAct   (pgAct),
    .readyAct(routerReady)
  );

  pgc_datapath #(
    .WAKE_LAT(WAKE_LAT),
    .BET_CYC (BET_CYC),
    .WIN_LEN (WIN_LEN),
    .RATE_W  (RATE_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .vcReq     (vcReq),
    .rateThresh(rateThresh),
    .strobe    (strobe),
    .wakeDone  (wakeDone),
    .rateHigh  (rateHigh),
    .betMet    (betMet)
  );

  for (genvar i = 0; i < NUM_NBR; i++) begin : gNbr
    assign pgOut[i] = pgAct;
    assign wuOut[i] = sendReq[i] & nbrPg[i];
  end

endmodule

// File: tb/router_gate_ctrl_test.sv
module router_gate_ctrl_test;

  localparam int WAKE_LAT = 12;
  localparam int BET_CYC  = 10;
  localparam int WIN_LEN  = 32;
  localparam int RATE_W   = $clog2(WIN_LEN + 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              modeSel;
  logic              dpEmpty;
  logic              vcReq;
  logic [RATE_W-1:0] rateThresh;
  logic [3:0]        nbrWake, nbrPg, sendReq;
  logic              sleepOut, routerReady, betMet;
  logic [3:0]        pgOut, wuOut;

  router_gate_ctrl #(
    .NUM_NBR(4), .WAKE_LAT(WAKE_LAT), .BET_CYC(BET_CYC), .WIN_LEN(WIN_LEN)
  ) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .dpEmpty(dpEmpty), .vcReq(vcReq),
    .rateThresh(rateThresh), .nbrWake(nbrWake), .nbrPg(nbrPg), .sendReq(sendReq),
    .sleepOut(sleepOut), .pgOut(pgOut), .wuOut(wuOut),
    .routerReady(routerReady), .betMet(betMet)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         cyc;
    logic       s;
    logic [3:0] p;
    logic       r;
    logic       b;
    logic [3:0] w;
    string      tag;
  } item_t;

  item_t sbQ[$];
  item_t keepQ[$];
  int    cyc = 0;
  int    edgeNo = 0;
  int    checks = 0;
  int    errors = 0;
  logic  expBet = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN) edgeNo <= edgeNo + 1;
  end

  // monitor: compare every queued expectation due in this cycle
  always @(negedge clk) begin
    keepQ.delete();
    for (int i = 0; i < sbQ.size(); i++) begin
      if (sbQ[i].cyc == cyc) begin
        checks++;
        if (sleepOut !== sbQ[i].s || pgOut !== sbQ[i].p || routerReady !== sbQ[i].r ||
            betMet !== sbQ[i].b || wuOut !== sbQ[i].w) begin
          errors++;
          $display("FAIL %s cyc=%0d: got sleep=%b pg=%h ready=%b bet=%b wu=%h, expected sleep=%b pg=%h ready=%b bet=%b wu=%h",
                   sbQ[i].tag, cyc, sleepOut, pgOut, routerReady, betMet, wuOut,
                   sbQ[i].s, sbQ[i].p, sbQ[i].r, sbQ[i].b, sbQ[i].w);
        end
      end else begin
        keepQ.push_back(sbQ[i]);
      end
    end
    sbQ = keepQ;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pushExp(int off, logic s, logic p, logic r, string tag);
    item_t it;
    it.cyc = cyc + off;
    it.s   = s;
    it.p   = p ? 4'hF : 4'h0;
    it.r   = r;
    it.b   = expBet;
    it.w   = sendReq & nbrPg;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // gate off, stay off for offCycles cycles, wake through a neighbor request
  task automatic gateAndWake(int offCycles, logic betNew);
    dpEmpty = 1'b1;
    pushExp(1, 0, 1, 0, "R2/R3 drain check");
    pushExp(2, 1, 1, 0, "R2 enter off");
    repeat (offCycles + 1) tick();
    nbrWake = 4'b0001;
    dpEmpty = 1'b0;
    expBet  = betNew;
    pushExp(1, 0, 1, 0, "R4/R8 waking");
    pushExp(WAKE_LAT, 0, 1, 0, "R5 still waking");
    pushExp(WAKE_LAT + 1, 0, 0, 1, "R5/R3 usable");
    tick();
    nbrWake = 4'b0000;
    repeat (WAKE_LAT + 2) tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; modeSel = 1'b0; dpEmpty = 1'b0; vcReq = 1'b0;
    rateThresh = RATE_W'(4); nbrWake = '0; nbrPg = '0; sendReq = '0;
    repeat (3) tick();
    rstN = 1'b1;
    pushExp(0, 0, 0, 1, "R1 reset state");
    pushExp(3, 0, 0, 1, "R1 idle on");
    repeat (4) tick();

    // R9: wake requests toward gated neighbors
    nbrPg = 4'b0011; sendReq = 4'b0110;
    pushExp(0, 0, 0, 1, "R9 mixed");
    tick();
    nbrPg = 4'b1111; sendReq = 4'b1111;
    pushExp(0, 0, 0, 1, "R9 all");
    tick();
    nbrPg = '0; sendReq = '0;
    tick();

    // R8: breakeven exactly reached, then one short
    gateAndWake(BET_CYC, 1'b1);
    gateAndWake(BET_CYC - 1, 1'b0);

    // R7: trigger during drain check aborts
    dpEmpty = 1'b1;
    tick();
    nbrWake = 4'b1000;
    pushExp(0, 0, 1, 0, "R7 in drain");
    pushExp(1, 0, 0, 1, "R7 aborted to on");
    tick();
    nbrWake = '0; dpEmpty = 1'b0;
    pushExp(2, 0, 0, 1, "R7 no sleep");
    repeat (3) tick();

    // R2: flit arrives during drain check
    dpEmpty = 1'b1;
    tick();
    dpEmpty = 1'b0;
    pushExp(0, 0, 1, 0, "R2 drain seen");
    pushExp(1, 0, 0, 1, "R2 back on, not empty");
    repeat (3) tick();

    // R6: rate-based wake
    modeSel = 1'b1; dpEmpty = 1'b1;
    pushExp(2, 1, 1, 0, "R6 off in rate mode");
    repeat (2) tick();
    nbrWake = 4'b1111;
    pushExp(2, 1, 1, 0, "R6 neighbor wake ignored");
    tick();
    nbrWake = '0;
    repeat (3) tick();
    while (edgeNo % WIN_LEN != 0) tick();
    vcReq = 1'b1;
    pushExp(WIN_LEN + 2, 1, 1, 0, "R6 count equal to threshold");
    repeat (4) tick();
    vcReq = 1'b0;
    tick();
    while (edgeNo % WIN_LEN != 0) tick();
    vcReq = 1'b1; dpEmpty = 1'b0;
    expBet = 1'b1;
    pushExp(WIN_LEN + 1, 0, 1, 0, "R6 count above threshold wakes");
    pushExp(WIN_LEN + 1 + WAKE_LAT, 0, 0, 1, "R6/R5 usable");
    repeat (5) tick();
    vcReq = 1'b0;
    repeat (WIN_LEN + WAKE_LAT + 4) tick();

    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending, expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule